// File: doc/BRIEF.md
# Floppy Sync and Address-Mark Detector

This block sits behind a data separator that already cuts the read stream into half-bit cells. Each half cell arrives as one `half_tick_i` pulse, and `flux_i` says whether that half cell held a flux transition. The detector first hunts for a long run of regularly spaced transitions, which is the synchronization field in front of every record. Once the run is long enough it declares lock, seeds its clock and data shift registers with the sync pattern, and pairs the following half cells into bit cells: a clock half first, then a data half.

The first data bit that breaks the sync pattern is the address mark. The block raises the mark flag and shifts seven more bit cells to finish the mark byte. It then pulses `byte_align_o` so that the downstream byte strobe starts on a byte boundary.

Two density modes change the spacing test, the seed values, the shift direction and the mark test. A loopback mode, with both read and write enabled, skips the bit pairing after lock. In that mode the mark is found by comparing whole bytes presented at a byte strobe. The spacing between transitions is measured in system clocks, against limits set by parameters.

Top module: `fsam_top`

## Requirements
- R1: After reset, `locked_o`, `mark_o` and `byte_align_o` are 0.
- R2: In high-density mode (`hd_mode_i`=1), a transition whose spacing from the previous one exceeds `HD_MAX_GAP` clocks resets the run count to 0. A spacing at or below the limit adds one to the run.
- R3: In low-density mode (`hd_mode_i`=0), a transition whose spacing is below `LD_MIN_GAP` clocks resets the run count to 0. A spacing at or above the limit adds one to the run.
- R4: The first transition after read is enabled only sets the spacing reference. `locked_o` rises one clock after the half tick of the transition that brings the run to `LOCK_RUN` (29) passing spacings.
- R5: On lock, the registers are seeded: `clock_o`=0x00 and `data_o`=0xFF in high-density mode, `clock_o`=0xFF and `data_o`=0x00 in low-density mode.
- R6: After lock in low-density mode, one half tick is discarded. From then on, half ticks pair as clock half followed by data half; in high-density mode the first half tick after lock is a clock half.
- R7: Each bit cell shifts both registers. In high-density mode they shift right, with the new bit entering bit 7. In low-density mode they shift left, with the new bit entering bit 0.
- R8: After lock, `mark_o` rises when the data bit shifted in is 0 (high density) or 1 (low density). Seven more bit cells are then shifted, and `byte_align_o` pulses for one clock right after the last of them.
- R9: While `read_en_i` is 0, lock, mark, run count and spacing reference are all cleared.
- R10: With `write_en_i` and `read_en_i` both 1 after lock, half ticks are not shifted. At a `byte_strobe_i`, `mark_o` rises when `loop_byte_i` differs from 0xFF (high density) or 0x00 (low density). No alignment pulse follows, and strobes before lock are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| read_en_i | input | 1 | Read path enable |
| write_en_i | input | 1 | Write path enable (loopback when both set) |
| hd_mode_i | input | 1 | 1 = high density, 0 = low density |
| half_tick_i | input | 1 | One pulse per half-bit cell |
| flux_i | input | 1 | Transition present in this half cell |
| byte_strobe_i | input | 1 | Byte strobe used in loopback |
| loop_byte_i | input | 8 | Data byte compared at a loopback strobe |
| locked_o | output | 1 | Sync run found |
| mark_o | output | 1 | Address mark detected |
| byte_align_o | output | 1 | One-clock pulse when the mark byte is complete |
| clock_o | output | 8 | Clock-bit shift register |
| data_o | output | 8 | Data-bit shift register |

## Verification
The assertions assume that `hd_mode_i` changes only while `read_en_i` is 0. They also assume that `half_tick_i` pulses last one clock and are spaced several clocks apart, so every register sees one half cell at a time. The stimulus changes the mode only during a read-disable gap. It drives every half cell as a single-clock tick followed by a fixed idle stretch, four clocks per half cell in high density and eight in low density. The resulting sync spacings, 8 and 16 clocks, fall clearly on the passing side of the two limits, while the deliberately broken runs fall on the failing side.

// File: rtl/fsam_pkg.sv
package fsam_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SKIP,
    ST_SEEK,
    ST_FILL,
    ST_DONE
  } fsam_state_e;
endpackage

// File: rtl/fsam_gap_timer.sv
module fsam_gap_timer #(
  parameter int GAP_W      = 8,
  parameter int HD_MAX_GAP = 9,
  parameter int LD_MIN_GAP = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic hit_i,
  input  logic hd_mode_i,
  output logic have_prev_o,
  output logic spacing_ok_o
);
  localparam logic [GAP_W-1:0] GAP_TOP = '1;
  localparam logic [GAP_W:0]   HD_LIM  = (GAP_W+1)'(HD_MAX_GAP);
  localparam logic [GAP_W:0]   LD_LIM  = (GAP_W+1)'(LD_MIN_GAP);

  logic [GAP_W-1:0] gap_q;
  logic             prev_q;
  logic [GAP_W:0]   spacing;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      prev_q <= 1'b0;
    end else if (clear_i) begin
      gap_q  <= '0;
      prev_q <= 1'b0;
    end else if (hit_i) begin
      gap_q  <= '0;
      prev_q <= 1'b1;
    end else if (gap_q != GAP_TOP) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // spacing in clocks from the previous transition tick to this one
  assign spacing      = {1'b0, gap_q} + 1'b1;
  assign spacing_ok_o = hd_mode_i ? (spacing <= HD_LIM) : (spacing >= LD_LIM);
  assign have_prev_o  = prev_q;

  p_clear_ref_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !have_prev_o);
endmodule

// File: rtl/fsam_run_counter.sv
module fsam_run_counter #(
  parameter int RUN_LEN = 29
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic pass_i,
  output logic lock_o
);
  localparam int          CW   = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
  localparam logic [CW-1:0] TOP  = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= pass_i ? cnt_q + 1'b1 : '0;
  end

  assign lock_o = step_i && pass_i && (cnt_q == LAST);

  p_run_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
  p_run_break_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !pass_i && !clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/fsam_shifter.sv
module fsam_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              preset_i,
  input  logic              hd_mode_i,
  input  logic              shift_i,
  input  logic              clk_bit_i,
  input  logic              dat_bit_i,
  output logic [BYTE_W-1:0] clock_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] clk_sr_q, dat_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sr_q <= '0;
      dat_sr_q <= '0;
    end else if (preset_i) begin
      clk_sr_q <= hd_mode_i ? '0 : '1;
      dat_sr_q <= hd_mode_i ? '1 : '0;
    end else if (shift_i) begin
      if (hd_mode_i) begin
        clk_sr_q <= {clk_bit_i, clk_sr_q[BYTE_W-1:1]};
        dat_sr_q <= {dat_bit_i, dat_sr_q[BYTE_W-1:1]};
      end else begin
        clk_sr_q <= {clk_sr_q[BYTE_W-2:0], clk_bit_i};
        dat_sr_q <= {dat_sr_q[BYTE_W-2:0], dat_bit_i};
      end
    end
  end

  assign clock_o = clk_sr_q;
  assign data_o  = dat_sr_q;

  p_shift_in_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !preset_i && hd_mode_i) |=> (data_o[BYTE_W-1] == $past(dat_bit_i)));
endmodule

// File: rtl/fsam_top.sv
module fsam_top
  import fsam_pkg::*;
#(
  parameter int GAP_W      = 8,
  parameter int HD_MAX_GAP = 9,
  parameter int LD_MIN_GAP = 14,
  parameter int LOCK_RUN   = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              read_en_i,
  input  logic              write_en_i,
  input  logic              hd_mode_i,
  input  logic              half_tick_i,
  input  logic              flux_i,
  input  logic              byte_strobe_i,
  input  logic [BYTE_W-1:0] loop_byte_i,
  output logic              locked_o,
  output logic              mark_o,
  output logic              byte_align_o,
  output logic [BYTE_W-1:0] clock_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int LW = $clog2(BYTE_W);
  localparam logic [LW-1:0] FILL_BITS = LW'(BYTE_W - 1);

  fsam_state_e state_q;
  logic          phase_q, clk_hold_q, mark_q, align_q;
  logic [LW-1:0] left_q;

  logic hit, have_prev, spacing_ok, step, lock_fire;
  logic tick_rd, data_half, mark_hit, loop_hit, in_byte;

  assign hit       = half_tick_i && flux_i && read_en_i;
  assign step      = hit && have_prev && (state_q == ST_HUNT);
  assign tick_rd   = half_tick_i && read_en_i && !write_en_i;
  assign in_byte   = (state_q == ST_SEEK) || (state_q == ST_FILL);
  assign data_half = tick_rd && phase_q && in_byte;
  assign mark_hit  = data_half && (state_q == ST_SEEK) && (hd_mode_i ? !flux_i : flux_i);
  assign loop_hit  = read_en_i && write_en_i && byte_strobe_i && (state_q == ST_SEEK) &&
                     (hd_mode_i ? (loop_byte_i != '1) : (loop_byte_i != '0));

  fsam_gap_timer #(.GAP_W(GAP_W), .HD_MAX_GAP(HD_MAX_GAP), .LD_MIN_GAP(LD_MIN_GAP)) u_gap (
    .clk_i, .rst_ni, .clear_i(!read_en_i), .hit_i(hit), .hd_mode_i,
    .have_prev_o(have_prev), .spacing_ok_o(spacing_ok)
  );

  fsam_run_counter #(.RUN_LEN(LOCK_RUN)) u_run (
    .clk_i, .rst_ni, .clear_i(!read_en_i), .step_i(step), .pass_i(spacing_ok),
    .lock_o(lock_fire)
  );

  fsam_shifter #(.BYTE_W(BYTE_W)) u_sr (
    .clk_i, .rst_ni, .preset_i(lock_fire), .hd_mode_i, .shift_i(data_half),
    .clk_bit_i(clk_hold_q), .dat_bit_i(flux_i), .clock_o, .data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      phase_q    <= 1'b0;
      clk_hold_q <= 1'b0;
      mark_q     <= 1'b0;
      align_q    <= 1'b0;
      left_q     <= '0;
    end else if (!read_en_i) begin
      state_q <= ST_HUNT;
      phase_q <= 1'b0;
      mark_q  <= 1'b0;
      align_q <= 1'b0;
      left_q  <= '0;
    end else begin
      align_q <= 1'b0;
      if (tick_rd && in_byte) begin
        phase_q <= !phase_q;
        if (!phase_q) clk_hold_q <= flux_i;
      end
      unique case (state_q)
        ST_HUNT: if (lock_fire) begin
          state_q <= hd_mode_i ? ST_SEEK : ST_SKIP;
          phase_q <= 1'b0;
        end
        // low density locks in a clock half: drop the data half after it
        ST_SKIP: if (half_tick_i) state_q <= ST_SEEK;
        ST_SEEK: begin
          if (loop_hit) begin
            mark_q  <= 1'b1;
            state_q <= ST_DONE;
          end else if (mark_hit) begin
            mark_q  <= 1'b1;
            left_q  <= FILL_BITS;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: if (data_half) begin
          left_q <= left_q - 1'b1;
          if (left_q == LW'(1)) begin
            align_q <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign locked_o     = (state_q != ST_HUNT);
  assign mark_o       = mark_q;
  assign byte_align_o = align_q;

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_en_i |=> (!locked_o && !mark_o && !byte_align_o));
  p_seed_hd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(locked_o) && $past(hd_mode_i)) |-> (data_o == '1 && clock_o == '0));
  p_seed_ld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(locked_o) && !$past(hd_mode_i)) |-> (data_o == '0 && clock_o == '1));
  p_mark_hd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mark_o) && !$past(write_en_i) && $past(hd_mode_i)) |-> !data_o[BYTE_W-1]);
  p_mark_ld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mark_o) && !$past(write_en_i) && !$past(hd_mode_i)) |-> data_o[0]);
  p_mark_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> locked_o);
  p_align_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_align_o |=> !byte_align_o);
  p_loop_no_align_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_align_o |-> !$past(write_en_i));
endmodule

// File: tb/tb_fsam_top.sv
module tb_fsam_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_HD = 4;
  localparam int T_LD = 8;
  // {hd, clock byte, data byte} of the mark byte following sync
  localparam logic [16:0] VEC [4] = '{
    {1'b1, 8'h0A, 8'hFE},
    {1'b1, 8'h00, 8'h5A},
    {1'b0, 8'hC7, 8'hFE},
    {1'b0, 8'hFF, 8'h80}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic read_en = 1'b0, write_en = 1'b0, hd = 1'b1;
  logic half_tick = 1'b0, flux = 1'b0, strobe = 1'b0;
  logic [7:0] loop_byte = 8'h00;
  logic locked, mark, align;
  logic [7:0] clock_v, data_v;
  int checks = 0, fails = 0, align_cnt = 0;

  fsam_top dut (
    .clk_i(clk), .rst_ni(rst_n), .read_en_i(read_en), .write_en_i(write_en),
    .hd_mode_i(hd), .half_tick_i(half_tick), .flux_i(flux), .byte_strobe_i(strobe),
    .loop_byte_i(loop_byte), .locked_o(locked), .mark_o(mark), .byte_align_o(align),
    .clock_o(clock_v), .data_o(data_v)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (align) align_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half(logic f);
    @(negedge clk); half_tick = 1'b1; flux = f;
    @(negedge clk); half_tick = 1'b0; flux = 1'b0;
    repeat ((hd ? T_HD : T_LD) - 2) @(negedge clk);
  endtask

  task automatic pair(logic c, logic d);
    half(c); half(d);
  endtask

  task automatic sync(int n);
    for (int i = 0; i < n; i++) pair(!hd, hd);
  endtask

  task automatic send_byte(logic [7:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      automatic int k = hd ? i : 7 - i;
      pair(c[k], d[k]);
    end
  endtask

  task automatic rd_off(logic mode);
    @(negedge clk); read_en = 1'b0; hd = mode;
    repeat (2) @(negedge clk);
    check("R9 lock cleared", locked, 0);
    check("R9 mark cleared", mark, 0);
    read_en = 1'b1;
  endtask

  task automatic lb_strobe(logic [7:0] b);
    @(negedge clk); strobe = 1'b1; loop_byte = b;
    @(negedge clk); strobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 locked after reset", locked, 0);
    check("R1 mark after reset", mark, 0);
    check("R1 align after reset", align, 0);
    rst_n = 1'b1;

    foreach (VEC[r]) begin
      automatic int a0;
      rd_off(VEC[r][16]);
      sync(32);
      check("R4 locked after sync", locked, 1);
      check("R5 seed data", data_v, hd ? 8'hFF : 8'h00);
      check("R5 seed clock", clock_v, hd ? 8'h00 : 8'hFF);
      check("R8 no mark in sync", mark, 0);
      a0 = align_cnt;
      send_byte(VEC[r][15:8], VEC[r][7:0]);
      check("R8 mark seen", mark, 1);
      check("R6 R7 data byte", data_v, VEC[r][7:0]);
      check("R6 R7 clock byte", clock_v, VEC[r][15:8]);
      check("R8 one align pulse", align_cnt, a0 + 1);
    end

    // R4: 29 transitions give 28 spacings, the 30th locks
    rd_off(1'b1);
    sync(29);
    check("R4 not locked at 28", locked, 0);
    sync(1);
    check("R4 locked at 29", locked, 1);

    // R2: long gap in high density breaks the run
    rd_off(1'b1);
    sync(20);
    pair(1'b0, 1'b0);
    sync(1);
    sync(28);
    check("R2 run restarted", locked, 0);
    sync(1);
    check("R2 locked after restart", locked, 1);

    // R3: short gap in low density breaks the run
    rd_off(1'b0);
    sync(10);
    pair(1'b1, 1'b1);
    sync(1);
    sync(28);
    check("R3 run restarted", locked, 0);
    sync(1);
    check("R3 locked after restart", locked, 1);

    // R9: disabling read forgets count and reference
    rd_off(1'b1);
    sync(20);
    rd_off(1'b1);
    sync(29);
    check("R9 count forgotten", locked, 0);
    sync(1);
    check("R9 relock", locked, 1);

    // R10: loopback, high density
    rd_off(1'b1);
    write_en = 1'b1;
    lb_strobe(8'hA1);
    check("R10 strobe before lock ignored", mark, 0);
    sync(30);
    check("R10 locked in loopback", locked, 1);
    begin
      automatic int a1 = align_cnt;
      for (int i = 0; i < 8; i++) pair(1'b1, 1'b0);
      check("R10 half ticks not shifted", mark, 0);
      check("R10 data unchanged", data_v, 8'hFF);
      lb_strobe(8'hFF);
      check("R10 sync byte no mark", mark, 0);
      lb_strobe(8'hA1);
      check("R10 mark on byte", mark, 1);
      repeat (4) @(negedge clk);
      check("R10 no align in loopback", align_cnt, a1);
    end

    // R10: loopback, low density
    rd_off(1'b0);
    sync(30);
    lb_strobe(8'h00);
    check("R10 ld sync byte no mark", mark, 0);
    lb_strobe(8'h01);
    check("R10 ld mark on byte", mark, 1);
    write_en = 1'b0;
    rd_off(1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule